// File: doc/BRIEF.md
# SPI Slave Control Register Interface

This block lets a host processor read and write a small file of 8-bit control registers over a four-wire serial link. The block acts only as a slave. A transfer opens when chip select goes low. It closes, or aborts, when chip select goes high again. The serial pins are resynchronised into the block's system clock, and every serial edge is detected inside that clock domain, so the whole design runs on one clock.

Every frame is 16 bits long, sent MSB first. The first bit is a direction flag, the next seven bits are the register address, and the last eight bits are the data. The block captures serial input on falling edges of the serial clock and launches read data on rising edges. All register contents are driven in parallel to the rest of the chip. One register holds two sticky fault flags, which hardware inputs set.

Top module: `spi_reg_if`

## Requirements
- R1: After reset the registers hold these values: 0x00 at addresses 0x00, 0x05, 0x06, 0x09, 0x0A, 0x0C and 0x10; 0x05 at 0x01 and 0x02; 0x08 at 0x03 and 0x04; 0x22 at 0x07; 0x09 at 0x08; 0x0F at 0x11.
- R2: A frame is sent MSB first and has three fields in this order: a direction bit (0 = write, 1 = read), a 7-bit address and an 8-bit data byte. A complete write frame stores the data byte at the given address.
- R3: In a read frame, the addressed register appears on `spi_miso_o` MSB first during the eight data slots. Each bit is launched after a rising edge of `spi_sclk_i` and is valid at the next falling edge.
- R4: `spi_miso_oe_o` is low whenever chip select is high and high while a transfer is in progress. Low means the output is high impedance.
- R5: A write takes effect only when at least 16 serial-clock falling edges have occurred before chip select rises. A rising chip select aborts any shorter frame and leaves all registers unchanged.
- R6: Falling edges after the sixteenth in the same frame are ignored. The first 16 bits decide the write.
- R7: A read from an unmapped address returns 0xFF. A write to an unmapped address changes no register.
- R8: `short_flag_i[0]` sets bit 3 of register 0x07 and `short_flag_i[1]` sets bit 7 of it. A set bit stays set after the input falls, until reset or a write to 0x07.
- R9: `regs_o` holds the registers in ascending address order, 8 bits each. Slot k holds the k-th mapped address: 0x00 to 0x0A in slots 0 to 10, then 0x0C, 0x10 and 0x11 in slots 11 to 13.
- R10: A read frame changes no register, whatever bits the host sends during its data slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sclk_i | input | 1 | Serial clock, idles high |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| spi_miso_oe_o | output | 1 | Output enable for spi_miso_o; low means high impedance |
| short_flag_i | input | 2 | Hardware set inputs for the sticky flags |
| regs_o | output | 112 | All registers in parallel, slot k at bits 8k+7..8k |

## Verification
The bench builds the block with a three-stage input synchroniser, one stage more than the default. This lengthens the delay from a serial edge to an internal event. Every serial half period in the bench lasts eight system clocks, so rise-to-launch timing on `spi_miso_o` is checked with that deeper latency, near the limit of the margin. With the default widths, the seven-bit address reaches both the unmapped holes inside the map and the space above it. The frame length is varied from 1 to 22 bits, which covers aborted frames, complete frames and frames that run over 16 bits.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int SR_W    = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int NREG    = 14;
  localparam int STATUS_IDX = 7;
  localparam int NFLAG   = 2;

  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{
    7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06,
    7'h07, 7'h08, 7'h09, 7'h0A, 7'h0C, 7'h10, 7'h11};

  localparam logic [DATA_W-1:0] REG_RST [NREG] = '{
    8'h00, 8'h05, 8'h05, 8'h08, 8'h08, 8'h00, 8'h00,
    8'h22, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F};

  // sticky flag bit positions inside the status register
  localparam int FLAG_POS [NFLAG] = '{3, 7};

  localparam logic [DATA_W-1:0] MISS_DATA = '1;

  function automatic logic [NREG-1:0] addr_decode(input logic [ADDR_W-1:0] a);
    logic [NREG-1:0] hit;
    for (int i = 0; i < NREG; i++) hit[i] = (a == REG_ADDR[i]);
    return hit;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              sclk_s_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic              sclk_d, csn_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [SR_W-1:0]   sr_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hold_q;
  logic              miso_q, oe_q, wr_en_q;

  logic              active, sclk_fall, sclk_rise, cs_rise;
  logic [HDR_W-1:0]  hdr_next;
  logic [CNT_W-1:0]  sel;

  assign active    = ~csn_s_i;
  assign sclk_fall = active & sclk_d & ~sclk_s_i;
  assign sclk_rise = active & ~sclk_d & sclk_s_i;
  assign cs_rise   = ~csn_d & csn_s_i;
  assign hdr_next  = {sr_q[HDR_W-2:0], mosi_s_i};
  assign sel       = CNT_LAST - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b1;
      csn_d   <= 1'b1;
      cnt_q   <= '0;
      sr_q    <= '0;
      dir_q   <= 1'b0;
      addr_q  <= '0;
      hold_q  <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      sclk_d  <= sclk_s_i;
      csn_d   <= csn_s_i;
      oe_q    <= active;
      wr_en_q <= cs_rise && (cnt_q == CNT_FULL) && !dir_q;
      if (csn_s_i) begin
        cnt_q <= '0;
      end else if (sclk_fall && cnt_q < CNT_FULL) begin
        sr_q  <= {sr_q[SR_W-2:0], mosi_s_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_HDR - 1'b1) begin
          dir_q  <= hdr_next[HDR_W-1];
          addr_q <= hdr_next[ADDR_W-1:0];
        end
      end
      // read data launched on rising edges during the data slots
      if (sclk_rise && dir_q && cnt_q >= CNT_HDR && cnt_q < CNT_FULL) begin
        if (cnt_q == CNT_HDR) begin
          hold_q <= rd_data_i;
          miso_q <= rd_data_i[DATA_W-1];
        end else begin
          miso_q <= hold_q[sel[BIT_W-1:0]];
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = sr_q[DATA_W-1:0];
  assign miso_o    = miso_q;
  assign miso_oe_o = oe_q;

  p_cnt_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  p_idle_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> (cnt_q == '0));
  p_oe_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> !oe_q);
  p_wr_after_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (cnt_q == '0));
  p_miso_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(miso_q));
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_reg_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [NFLAG-1:0]       flag_set_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [NREG-1:0] wr_hit, rd_hit;
  logic [DATA_W-1:0] reg_val [NREG];

  assign wr_hit = addr_decode(wr_addr_i);
  assign rd_hit = addr_decode(rd_addr_i);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] set_mask;
    if (i == STATUS_IDX) begin : g_sticky
      always_comb begin
        set_mask = '0;
        for (int f = 0; f < NFLAG; f++) set_mask[FLAG_POS[f]] = flag_set_i[f];
      end
    end else begin : g_plain
      assign set_mask = '0;
    end
    // hardware set wins over a same-cycle write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q <= REG_RST[i];
      else if (wr_en_i && wr_hit[i]) q <= wr_data_i | set_mask;
      else                          q <= q | set_mask;
    end
    assign reg_val[i] = q;
    assign regs_o[i*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_data_o = MISS_DATA;
    for (int i = 0; i < NREG; i++) if (rd_hit[i]) rd_data_o = reg_val[i];
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag_chk
    p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_set_i[f] |=> reg_val[STATUS_IDX][FLAG_POS[f]]);
    p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_val[STATUS_IDX][FLAG_POS[f]] && !(wr_en_i && wr_hit[STATUS_IDX]))
      |=> reg_val[STATUS_IDX][FLAG_POS[f]]);
  end
endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   spi_csn_i,
  input  logic                   spi_sclk_i,
  input  logic                   spi_mosi_i,
  output logic                   spi_miso_o,
  output logic                   spi_miso_oe_o,
  input  logic [NFLAG-1:0]       short_flag_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic              csn_s, sclk_s, mosi_s;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;

  spi_in_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b110)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_csn_i, spi_sclk_i, spi_mosi_i}),
    .q_o   ({csn_s, sclk_s, mosi_s})
  );

  spi_frame i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .csn_s_i  (csn_s),
    .sclk_s_i (sclk_s),
    .mosi_s_i (mosi_s),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .miso_o   (spi_miso_o),
    .miso_oe_o(spi_miso_oe_o)
  );

  spi_reg_file i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .flag_set_i(short_flag_i),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );

  p_no_write_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> csn_s);
endmodule

// File: tb/test_spi_reg_if.sv
module test_spi_reg_if;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csn = 1'b1, sclk = 1'b1, mosi = 1'b0;
  logic         miso, miso_oe;
  logic [1:0]   short_flag = 2'b00;
  logic [111:0] regs;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [128];
  logic [6:0] slot_addr [14];

  always #10 clk = ~clk;

  spi_reg_if #(.SYNC_STAGES(3)) i_spi_reg_if (
    .clk_i(clk), .rst_ni(rst_n), .spi_csn_i(csn), .spi_sclk_i(sclk),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .short_flag_i(short_flag), .regs_o(regs));

  function automatic bit is_mapped(input logic [6:0] a);
    return (a <= 7'h0A) || a == 7'h0C || a == 7'h10 || a == 7'h11;
  endfunction

  function automatic logic [7:0] rst_val(input logic [6:0] a);
    case (a)
      7'h01, 7'h02: return 8'h05;
      7'h03, 7'h04: return 8'h08;
      7'h07:        return 8'h22;
      7'h08:        return 8'h09;
      7'h11:        return 8'h0F;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    return is_mapped(a) ? model[a] : 8'hFF;
  endfunction

  task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    bit ok = 1;
    for (int k = 0; k < 14; k++) begin
      if (regs[k*8 +: 8] !== model[slot_addr[k]]) begin
        ok = 0;
        $display("FAIL %s: slot %0d got %02h expected %02h", req, k,
                 regs[k*8 +: 8], model[slot_addr[k]]);
      end
    end
    checks++;
    if (!ok) errors++;
  endtask

  task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rd);
    rd = 'x;
    csn = 1'b0;
    wait_clk(HALF);
    check8("R4 oe active", {7'b0, miso_oe}, 8'h01);
    for (int i = 0; i < nbits; i++) begin
      if (i == 0)       mosi = rw;
      else if (i < 8)   mosi = a[7-i];
      else if (i < 16)  mosi = wd[15-i];
      else              mosi = 1'($urandom);
      wait_clk(HALF);
      if (i >= 8 && i < 16) rd[15-i] = miso;
      sclk = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(12);
    if (!rw && nbits >= 16 && is_mapped(a)) model[a] = wd;
  endtask

  task automatic read_chk(input string req, input logic [6:0] a);
    logic [7:0] r;
    xfer(1'b1, a, 8'($urandom), 16, r);
    check8(req, r, exp_read(a));
  endtask

  task automatic pulse_flag(input logic [1:0] f);
    short_flag = f;
    wait_clk(3);
    short_flag = 2'b00;
    wait_clk(2);
    if (f[0]) model[7][3] = 1'b1;
    if (f[1]) model[7][7] = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5eed1234));
    begin
      int k = 0;
      for (int a = 0; a < 128; a++) begin
        model[a] = rst_val(7'(a));
        if (is_mapped(7'(a))) begin slot_addr[k] = 7'(a); k++; end
      end
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 R9 R4: reset state
    check8("R4 oe idle", {7'b0, miso_oe}, 8'h00);
    check_regs("R1 R9 reset image");
    for (int k = 0; k < 14; k++) read_chk("R1 R3 reset read", slot_addr[k]);

    // R2 write then read back
    xfer(1'b0, 7'h03, 8'hA5, 16, r);
    read_chk("R2 write readback", 7'h03);
    check_regs("R9 after write");
    check8("R4 oe idle after", {7'b0, miso_oe}, 8'h00);

    // R7 unmapped
    read_chk("R7 unmapped 0x0B", 7'h0B);
    read_chk("R7 unmapped 0x7F", 7'h7F);
    xfer(1'b0, 7'h0B, 8'h12, 16, r);
    check_regs("R7 unmapped write ignored");

    // R5 short frames
    xfer(1'b0, 7'h01, 8'hEE, 12, r);
    check_regs("R5 12-bit frame");
    xfer(1'b0, 7'h01, 8'hEF, 15, r);
    check_regs("R5 15-bit frame");
    read_chk("R5 reg unchanged", 7'h01);

    // R6 long frame
    xfer(1'b0, 7'h02, 8'h3C, 20, r);
    read_chk("R6 long write", 7'h02);

    // R10 read does not modify
    xfer(1'b1, 7'h04, 8'h77, 16, r);
    check8("R10 read value", r, model[7'h04]);
    check_regs("R10 read no modify");

    // R8 sticky flags
    pulse_flag(2'b01);
    read_chk("R8 flag bit3 set", 7'h07);
    read_chk("R8 flag bit3 held", 7'h07);
    xfer(1'b0, 7'h07, 8'h00, 16, r);
    read_chk("R8 cleared by write", 7'h07);
    pulse_flag(2'b10);
    read_chk("R8 flag bit7 set", 7'h07);
    check_regs("R8 R9 flag image");

    // random traffic
    for (int n = 0; n < 150; n++) begin
      logic [6:0] a;
      bit rw;
      int nb;
      logic [7:0] wd;
      a  = ($urandom_range(0, 1) == 0) ? slot_addr[$urandom_range(0, 13)] : 7'($urandom);
      rw = 1'($urandom);
      nb = ($urandom_range(0, 9) < 7) ? 16 : $urandom_range(1, 22);
      wd = 8'($urandom);
      if ($urandom_range(0, 15) == 0) pulse_flag(2'($urandom));
      xfer(rw, a, wd, nb, r);
      if (rw && nb >= 16) check8("R3 R7 random read", r, exp_read(a));
      check_regs("R2 R5 R6 R9 random image");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule